// File: doc/BRIEF.md
# Three-Mode Programmable Output Macrocell Array

This block is the logic core of a small programmable logic device: a programmable AND plane feeding eight sum-of-products output cells. Each cell owns eight product terms. A term is built from the true or complement literals of every array signal. The array signals are the dedicated inputs plus one column for each cell. The column carries that cell's feedback or, in some modes, one of two shared pins. All configuration (global mode, per-cell role bits, per-term enables and literal connections) arrives on static configuration ports that the surrounding chip holds stable.

A two-bit global mode selects one of three architectures. The mode sets how many terms reach each sum, where each output enable comes from, and what each feedback column carries. In registered mode the shared clock pin drives the cell registers and the shared active-low enable pin gates every registered output. In the other modes the two shared pins become plain array inputs. The cells at both ends and in the centre have fixed role exceptions. An asynchronous active-low reset models power-up and clears every register.

Top module: `pld_macro_array`

## Requirements
- R1: In registered mode (`cfg_mode` = 2), a cell with `cfg_regcell`=1 and `cfg_incell`=0 is registered. At each rising clock edge it captures the OR of all eight of its terms, adjusted by polarity. Its pad shows the inverse of the stored bit, which equals that adjusted sum from before the edge. Its pad enable is the inverse of `goe_pin`.
- R2: In registered mode, a non-registered, non-input cell is combinational. Term 0 is its output enable, and its output is the OR of terms 1 to 7, adjusted by polarity.
- R3: A cell acting as a dedicated input has its pad enable held at 0. This covers every cell with `cfg_incell`=1 in registered mode, every such cell except the two end cells in complex mode, and every such cell except the two centre cells in simple mode.
- R4: In registered mode, column c carries the register of cell c when that cell is registered, and `pad_in[c]` otherwise. `gclk_data` and `goe_pin` never reach the array.
- R5: In complex mode (`cfg_mode` = 1), column 0 carries `gclk_data` and the last column carries `goe_pin`. Every other column carries its own pad. The end cells (0 and N_CELL-1) are always outputs, whatever their `cfg_incell` bit says. Every cell uses term 0 as its enable and ORs terms 1 to 7.
- R6: In simple mode (`cfg_mode` = 0 or 3), every output cell ORs all eight terms and is always enabled. The centre cells (N_CELL/2-1 and N_CELL/2) are always outputs. Column 0 and the last column carry `gclk_data` and `goe_pin`. Column c, for 1 <= c < N_CELL/2, carries `pad_in[c-1]`. Column c, for N_CELL/2 <= c <= N_CELL-2, carries `pad_in[c+1]`. The centre pads therefore feed no column.
- R7: While `rst_n` is low, every register is 0, so every registered pad drives 1.
- R8: Term t of cell c uses bits [(c*N_PT+t)*N_LIT +: N_LIT] of `cfg_fuse`, where bit 2s selects the true form of array signal s and bit 2s+1 selects its complement. Signal s < N_IN is `din[s]`; signal N_IN+k is column k. A term evaluates to 1 only when its enable bit `cfg_term_en[c*N_PT+t]` is 1 and every selected literal is 1. So a disabled term gives 0, a term with no literal selected gives 1, and a term that selects both forms of any signal gives 0.
- R9: With `cfg_inv[c]`=1 the cell's sum is inverted before it reaches the pad (for registered cells, before it is stored). With 0 the sum is passed true.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Shared clock pin, clocks the cell registers |
| rst_n | input | 1 | Asynchronous active-low power-up reset |
| cfg_mode | input | 2 | Global mode: 0/3 simple, 1 complex, 2 registered |
| cfg_regcell | input | N_CELL | Per-cell registered select (registered mode) |
| cfg_incell | input | N_CELL | Per-cell dedicated-input select |
| cfg_inv | input | N_CELL | Per-cell output polarity, 1 = inverted |
| cfg_term_en | input | N_CELL*N_PT | Per-term enable |
| cfg_fuse | input | N_CELL*N_PT*2*(N_IN+N_CELL) | Per-term literal connections |
| din | input | N_IN | Dedicated array inputs |
| gclk_data | input | 1 | Data value on the shared clock pin |
| goe_pin | input | 1 | Shared enable pin (active low in registered mode) |
| pad_in | input | N_CELL | Value seen on each cell pad |
| pad_out | output | N_CELL | Value each cell drives on its pad |
| pad_oe | output | N_CELL | Pad drive enable per cell |

## Verification
The bench builds the block with its defaults: eight cells, eight terms each and eight dedicated inputs, which gives 32 literals per term. With eight cells, the end cells 0 and 7 and the centre cells 3 and 4 are distinct. So the fixed role exceptions, the column shift around the centre in simple mode, and the shared pins taking over the end columns are all checked. Random literal sets are kept to at most three literals per term, so that terms evaluate to 1 often enough for register feedback through the columns to affect the outputs.

// File: rtl/pld_pkg.sv
package pld_pkg;

    typedef enum logic [1:0] {
        MODE_SIMPLE     = 2'd0,
        MODE_COMPLEX    = 2'd1,
        MODE_REG        = 2'd2,
        MODE_SIMPLE_ALT = 2'd3
    } pld_mode_e;

endpackage

// File: rtl/pld_and_plane.sv
module pld_and_plane #(
    parameter int N_PT  = 8,
    parameter int N_LIT = 32
) (
    input  logic [N_LIT-1:0]      lits,
    input  logic [N_PT*N_LIT-1:0] fuse,
    input  logic [N_PT-1:0]       en,
    output logic [N_PT-1:0]       pt
);

    // A term is true when enabled and every connected literal is true.
    for (genvar t = 0; t < N_PT; t++) begin : g_term
        assign pt[t] = en[t] & (&(~fuse[t*N_LIT +: N_LIT] | lits));
    end

endmodule

// File: rtl/pld_col_route.sv
module pld_col_route
    import pld_pkg::*;
#(
    parameter int N_CELL = 8
) (
    input  pld_mode_e         mode,
    input  logic [N_CELL-1:0] regcell,
    input  logic [N_CELL-1:0] incell,
    input  logic [N_CELL-1:0] q,
    input  logic [N_CELL-1:0] pad_in,
    input  logic              gclk_data,
    input  logic              goe_pin,
    output logic [N_CELL-1:0] col
);

    localparam int HALF = N_CELL / 2;

    for (genvar c = 0; c < N_CELL; c++) begin : g_col
        // neighbour pad used in simple mode; end columns take the shared pins
        localparam int SRC = (c == 0 || c == N_CELL - 1) ? c :
                             (c < HALF) ? c - 1 : c + 1;
        logic col_b;

        always_comb begin
            if (mode == MODE_REG) begin
                col_b = (regcell[c] & ~incell[c]) ? q[c] : pad_in[c];
            end else if (c == 0) begin
                col_b = gclk_data;
            end else if (c == N_CELL - 1) begin
                col_b = goe_pin;
            end else if (mode == MODE_COMPLEX) begin
                col_b = pad_in[c];
            end else begin
                col_b = pad_in[SRC];
            end
        end

        assign col[c] = col_b;
    end

endmodule

// File: rtl/pld_cell.sv
module pld_cell
    import pld_pkg::*;
#(
    parameter int N_PT      = 8,
    parameter bit IS_OUTER  = 1'b0,
    parameter bit IS_CENTRE = 1'b0
) (
    input  pld_mode_e       mode,
    input  logic            regcell,
    input  logic            incell,
    input  logic            inv,
    input  logic [N_PT-1:0] pt,
    input  logic            goe_pin,
    input  logic            q,
    output logic            d,
    output logic            load,
    output logic            out,
    output logic            oe
);

    logic is_reg_mode;
    logic is_cplx;
    logic is_input;
    logic use_reg;
    logic use_oe_term;
    logic sum;
    logic comb;

    always_comb begin
        is_reg_mode = (mode == MODE_REG);
        is_cplx     = (mode == MODE_COMPLEX);

        if (is_reg_mode)  is_input = incell;
        else if (is_cplx) is_input = incell & ~IS_OUTER;
        else              is_input = incell & ~IS_CENTRE;

        use_reg     = is_reg_mode & regcell & ~incell;
        use_oe_term = (is_reg_mode & ~use_reg) | is_cplx;

        // term 0 is stolen for the enable when the cell needs one
        sum  = use_oe_term ? (|pt[N_PT-1:1]) : (|pt);
        comb = sum ^ inv;

        // register stores the complement; the pad inverts it back
        d    = ~comb;
        load = use_reg;
        out  = use_reg ? ~q : comb;

        if (is_input)         oe = 1'b0;
        else if (use_reg)     oe = ~goe_pin;
        else if (use_oe_term) oe = pt[0];
        else                  oe = 1'b1;
    end

endmodule

// File: rtl/pld_macro_array.sv
module pld_macro_array
    import pld_pkg::*;
#(
    parameter int N_CELL = 8,
    parameter int N_PT   = 8,
    parameter int N_IN   = 8
) (
    input  logic                                    clk,
    input  logic                                    rst_n,
    input  logic [1:0]                              cfg_mode,
    input  logic [N_CELL-1:0]                       cfg_regcell,
    input  logic [N_CELL-1:0]                       cfg_incell,
    input  logic [N_CELL-1:0]                       cfg_inv,
    input  logic [N_CELL*N_PT-1:0]                  cfg_term_en,
    input  logic [N_CELL*N_PT*2*(N_IN+N_CELL)-1:0]  cfg_fuse,
    input  logic [N_IN-1:0]                         din,
    input  logic                                    gclk_data,
    input  logic                                    goe_pin,
    input  logic [N_CELL-1:0]                       pad_in,
    output logic [N_CELL-1:0]                       pad_out,
    output logic [N_CELL-1:0]                       pad_oe
);

    localparam int N_SIG       = N_IN + N_CELL;
    localparam int N_LIT       = 2 * N_SIG;
    localparam int CELL_FUSE_W = N_PT * N_LIT;
    localparam int MID_LO      = N_CELL / 2 - 1;
    localparam int MID_HI      = N_CELL / 2;

    typedef struct packed {
        logic [N_CELL-1:0] q;
    } state_t;

    state_t st_d, st_q;

    pld_mode_e         mode;
    logic [N_CELL-1:0] col;
    logic [N_SIG-1:0]  sig;
    logic [N_LIT-1:0]  lits;
    logic [N_CELL-1:0] d_w;
    logic [N_CELL-1:0] load_w;

    assign mode = pld_mode_e'(cfg_mode);

    pld_col_route #(.N_CELL(N_CELL)) u_route (
        .mode      (mode),
        .regcell   (cfg_regcell),
        .incell    (cfg_incell),
        .q         (st_q.q),
        .pad_in    (pad_in),
        .gclk_data (gclk_data),
        .goe_pin   (goe_pin),
        .col       (col)
    );

    assign sig = {col, din};

    for (genvar s = 0; s < N_SIG; s++) begin : g_lit
        assign lits[2*s]   = sig[s];
        assign lits[2*s+1] = ~sig[s];
    end

    for (genvar c = 0; c < N_CELL; c++) begin : g_cell
        logic [N_PT-1:0] pt_w;

        pld_and_plane #(.N_PT(N_PT), .N_LIT(N_LIT)) u_plane (
            .lits (lits),
            .fuse (cfg_fuse[c*CELL_FUSE_W +: CELL_FUSE_W]),
            .en   (cfg_term_en[c*N_PT +: N_PT]),
            .pt   (pt_w)
        );

        pld_cell #(
            .N_PT      (N_PT),
            .IS_OUTER  (c == 0 || c == N_CELL - 1),
            .IS_CENTRE (c == MID_LO || c == MID_HI)
        ) u_cell (
            .mode    (mode),
            .regcell (cfg_regcell[c]),
            .incell  (cfg_incell[c]),
            .inv     (cfg_inv[c]),
            .pt      (pt_w),
            .goe_pin (goe_pin),
            .q       (st_q.q[c]),
            .d       (d_w[c]),
            .load    (load_w[c]),
            .out     (pad_out[c]),
            .oe      (pad_oe[c])
        );

        assert_input_oe_off_R3: assert property (@(posedge clk) disable iff (!rst_n)
            (mode == MODE_REG && cfg_incell[c]) |-> !pad_oe[c]);

        assert_reg_oe_pin_R1: assert property (@(posedge clk) disable iff (!rst_n)
            (mode == MODE_REG && cfg_regcell[c] && !cfg_incell[c]) |-> (pad_oe[c] == !goe_pin));

        assert_reg_capture_R1: assert property (@(posedge clk) disable iff (!rst_n)
            ($past(rst_n) && mode == MODE_REG && cfg_regcell[c] && !cfg_incell[c] &&
             $past(mode == MODE_REG && cfg_regcell[c] && !cfg_incell[c]))
            |-> (pad_out[c] == !$past(d_w[c])));
    end

    always_comb begin
        st_d = st_q;
        for (int c = 0; c < N_CELL; c++) begin
            if (load_w[c]) st_d.q[c] = d_w[c];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assert_reset_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (st_q.q == '0));

    assert_simple_centre_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MODE_SIMPLE || mode == MODE_SIMPLE_ALT) |-> (pad_oe[MID_LO] && pad_oe[MID_HI]));

endmodule

// File: tb/pld_macro_array_tb.sv
module pld_macro_array_tb_top;

    localparam int NC = 8;
    localparam int NP = 8;
    localparam int NI = 8;
    localparam int NS = NI + NC;
    localparam int NL = 2 * NS;
    localparam int FW = NC * NP * NL;

    logic          clk = 1'b0;
    logic          rst_n;
    logic [1:0]    cfg_mode;
    logic [NC-1:0] cfg_regcell, cfg_incell, cfg_inv;
    logic [NC*NP-1:0] cfg_term_en;
    logic [FW-1:0] cfg_fuse;
    logic [NI-1:0] din;
    logic          gclk_data, goe_pin;
    logic [NC-1:0] pad_in, pad_out, pad_oe;
    logic [NC-1:0] mq;

    int  checks = 0;
    int  errors = 0;
    bit  done   = 1'b0;

    always #4 clk = ~clk;

    pld_macro_array #(.N_CELL(NC), .N_PT(NP), .N_IN(NI)) dut_i (
        .clk(clk), .rst_n(rst_n), .cfg_mode(cfg_mode), .cfg_regcell(cfg_regcell),
        .cfg_incell(cfg_incell), .cfg_inv(cfg_inv), .cfg_term_en(cfg_term_en),
        .cfg_fuse(cfg_fuse), .din(din), .gclk_data(gclk_data), .goe_pin(goe_pin),
        .pad_in(pad_in), .pad_out(pad_out), .pad_oe(pad_oe)
    );

    // Reference model written from the requirements.
    function automatic void model(output logic [NC-1:0] eo, output logic [NC-1:0] eoe,
                                  output logic [NC-1:0] nq);
        logic [NC-1:0] col;
        logic [NS-1:0] sig;
        logic [NL-1:0] lit;
        logic [NP-1:0] pt;
        logic sum, comb, isin, usereg, useoe, outer, centre;
        int m;
        m = int'(cfg_mode);
        for (int c = 0; c < NC; c++) begin
            if (m == 2)           col[c] = (cfg_regcell[c] && !cfg_incell[c]) ? mq[c] : pad_in[c];
            else if (c == 0)      col[c] = gclk_data;
            else if (c == NC - 1) col[c] = goe_pin;
            else if (m == 1)      col[c] = pad_in[c];
            else if (c < NC / 2)  col[c] = pad_in[c-1];
            else                  col[c] = pad_in[c+1];
        end
        sig = {col, din};
        for (int s = 0; s < NS; s++) begin
            lit[2*s]   = sig[s];
            lit[2*s+1] = ~sig[s];
        end
        for (int c = 0; c < NC; c++) begin
            for (int t = 0; t < NP; t++)
                pt[t] = cfg_term_en[c*NP+t] && ((cfg_fuse[(c*NP+t)*NL +: NL] & ~lit) == '0);
            outer  = (c == 0) || (c == NC - 1);
            centre = (c == NC/2 - 1) || (c == NC/2);
            if (m == 2)      isin = cfg_incell[c];
            else if (m == 1) isin = cfg_incell[c] && !outer;
            else             isin = cfg_incell[c] && !centre;
            usereg = (m == 2) && cfg_regcell[c] && !cfg_incell[c];
            useoe  = ((m == 2) && !usereg) || (m == 1);
            sum    = useoe ? |pt[NP-1:1] : |pt;
            comb   = sum ^ cfg_inv[c];
            eo[c]  = usereg ? ~mq[c] : comb;
            if (isin)        eoe[c] = 1'b0;
            else if (usereg) eoe[c] = ~goe_pin;
            else if (useoe)  eoe[c] = pt[0];
            else             eoe[c] = 1'b1;
            nq[c]  = usereg ? ~comb : mq[c];
        end
    endfunction

    task automatic check(input string req, input string what,
                         input logic [NC-1:0] act, input logic [NC-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    // Called just after a falling edge with inputs already driven.
    task automatic step(input string req);
        logic [NC-1:0] eo, eoe, nq;
        #2;
        model(eo, eoe, nq);
        check(req, "pad_oe", pad_oe, eoe);
        check(req, "pad_out", pad_out & eoe, eo & eoe);
        @(posedge clk);
        #1;
        mq = nq;
    endtask

    task automatic rand_cfg(input int m);
        logic [NL-1:0] fld;
        cfg_mode    = 2'(m);
        cfg_regcell = NC'($urandom);
        cfg_incell  = NC'($urandom & $urandom);
        cfg_inv     = NC'($urandom);
        for (int i = 0; i < NC * NP; i++) begin
            cfg_term_en[i] = ($urandom_range(0, 7) != 0);
            fld = '0;
            repeat ($urandom_range(0, 3)) fld[$urandom_range(0, NL - 1)] = 1'b1;
            cfg_fuse[i*NL +: NL] = fld;
        end
    endtask

    task automatic rand_pins();
        din       = NI'($urandom);
        pad_in    = NC'($urandom);
        gclk_data = 1'($urandom);
        goe_pin   = ($urandom_range(0, 3) == 0);
    endtask

    initial begin
        #(8 * 200000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        string tag;
        void'($urandom(32'd7321));
        rst_n = 1'b0; mq = '0;
        cfg_mode = 2'd2; cfg_regcell = '1; cfg_incell = '0; cfg_inv = '1;
        cfg_term_en = '1; cfg_fuse = '0;
        din = '0; gclk_data = 1'b0; goe_pin = 1'b0; pad_in = '0;

        // R7: registers held low in reset, registered pads high
        #10;
        check("R7", "reset pad_out", pad_out, '1);
        check("R7", "reset pad_oe", pad_oe, '1);
        @(posedge clk); #2;
        check("R7", "pad_out held across edge in reset", pad_out, '1);

        // R1 R9: inverted sum of constant-1 terms is captured after release
        @(negedge clk); rst_n = 1'b1;
        step("R1 R9 first edge");
        @(negedge clk);
        step("R1 R9 captured");
        check("R1", "registered pad after capture", pad_out, '0);
        @(negedge clk); goe_pin = 1'b1; #2;
        check("R1", "shared enable pin high", pad_oe, '0);

        // R3: input cells in registered mode
        cfg_incell = '1; #2;
        check("R3", "registered-mode inputs", pad_oe, '0);

        // R8: term evaluation corner cases in simple mode
        @(negedge clk);
        cfg_mode = 2'd0; cfg_incell = '0; cfg_inv = '0; cfg_term_en = '0; cfg_fuse = '0;
        cfg_term_en[0*NP] = 1'b1; cfg_fuse[0*NP*NL +: NL] = '1;
        cfg_term_en[1*NP] = 1'b1;
        cfg_term_en[2*NP] = 1'b0;
        #2;
        check("R8", "all-literal/no-literal/disabled terms", pad_out & 8'h07, 8'h02);
        check("R6", "simple mode enables", pad_oe, '1);

        // R6: centre cells stay outputs in simple mode (alternate encoding)
        cfg_mode = 2'd3; cfg_incell = '1; #2;
        check("R6", "centre cells forced out", pad_oe, 8'h18);

        // R5: end cells ignore the input select in complex mode
        cfg_mode = 2'd1; cfg_term_en = '1; cfg_fuse = '0; #2;
        check("R5", "end cells output-only", pad_oe, 8'h81);
        check("R5", "end cell sums", pad_out & 8'h81, 8'h81);

        // R4: column 0 carries cell 0 pad, not the clock pin data, in registered mode
        cfg_mode = 2'd2; cfg_incell = '0; cfg_regcell = '0; cfg_inv = '0;
        cfg_term_en = '0; cfg_fuse = '0;
        cfg_term_en[1*NP+0] = 1'b1; cfg_term_en[1*NP+1] = 1'b1;
        cfg_fuse[(1*NP+1)*NL + 2*NI] = 1'b1;
        pad_in = 8'h01; gclk_data = 1'b0; #2;
        check("R4 R2", "column 0 from pad", pad_out & 8'h02, 8'h02);
        pad_in = 8'h00; gclk_data = 1'b1; #2;
        check("R4 R2", "clock pin data kept out", pad_out & 8'h02, 8'h00);
        @(posedge clk); #1;

        // Random blocks in every mode
        for (int m = 0; m < 4; m++) begin
            if (m == 2)      tag = "R1 R2 R3 R4 R9";
            else if (m == 1) tag = "R5 R3 R8";
            else             tag = "R6 R8 R9";
            for (int b = 0; b < 8; b++) begin
                @(negedge clk);
                rand_cfg(m);
                for (int i = 0; i < 12; i++) begin
                    if (i > 0) @(negedge clk);
                    rand_pins();
                    step(tag);
                end
            end
        end

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule